// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial-flash transaction each time software writes the start bit. A transaction always follows the same order. It sends an opcode phase first. An address phase, a phase of idle dummy clocks and a data phase may follow. Each phase can be switched on or off, and each has its own lane width of one, two or four lines. Software sets the whole transaction up through eight 32-bit word registers, writes the control word, and polls the status word until the transfer-end flag appears.

At most four data bytes move per start. To go beyond four bytes, software sets the hold-select bit. Chip select then stays low after the transaction. The next start clears the opcode and address enables, so it only carries more data inside the same frame. The serial clock runs at `clk / (2*SCK_HALF)`, idles low and is sampled on its rising edge (mode 0). Outgoing bits change only while the clock is low.

Register words, selected by `bus_addr`:
- 0: control. Bit 0 is start, bit 1 is read, bit 2 is write, bit 3 is hold-select.
- 1: opcode, in [7:0].
- 2: address.
- 3: dummy count minus one, in [4:0].
- 4: phase setup. Bit 0 enables the opcode phase and bit 1 enables dummy clocks. [7:4] is the address byte mask and [11:8] is the data byte mask. [13:12], [15:14] and [17:16] are the lane codes for opcode, address and data.
- 5: write data.
- 6: read data.
- 7: status.

Top module: `spi_mseq`

## Requirements
- R1: Phases run in the order opcode, address, dummy, data, and a disabled phase is skipped. Each bit slot holds `sck` low for SCK_HALF cycles and then high for SCK_HALF cycles. `sck` is low whenever no transaction runs, and it never pulses while `cs_n` is high.
- R2: The opcode phase shifts out the 8-bit opcode word, most significant bit first.
- R3: The number of address bytes equals the number of set bits in the address mask (0x7 gives 3 bytes, 0xF gives 4). These bytes are the low bytes of the address word, sent most significant first.
- R4: The dummy phase lasts the dummy count plus one slots (1 to 32), and no lane is driven during it.
- R5: Lane code 0 drives `io_out[0]` (with `io_oe`=0001) and samples `io_in[1]`. Code 1 uses lanes [1:0] (`io_oe`=0011). Code 2 uses lanes [3:0] (`io_oe`=1111). Code 3 behaves as code 0. The higher lane index carries the earlier bit, and an undriven lane outputs 0.
- R6: A write data phase sends as many bytes as the data mask has set bits (0x8 gives 1, 0xC gives 2, 0xF gives 4), starting from the top byte of the write-data word.
- R7: A read data phase tri-states all lanes. Received bytes fill the read-data word from its top byte, and bytes not received read as zero. If both read and write are set, the phase reads. If neither is set, the data phase is skipped.
- R8: If a start carries hold-select, `cs_n` stays low after that transaction. The next start keeps the frame without a high pulse, and the frame is released when a start without hold-select finishes.
- R9: Status bit 0 (transfer end) rises as the sequence finishes and stays set until the next accepted start clears it. Status bit 1 is 1 while `cs_n` is low.
- R10: While a transaction runs, writes to any register, including a start, are ignored.
- R11: A start with no phase enabled finishes at once. The transfer-end flag is set on the next cycle and no clock pulse is produced.
- R12: After reset, `cs_n` is high, `sck` is low, `io_oe` is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word select |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on `bus_addr`) |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | Data lane output values |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Data lane input values |

## Verification
The bench builds the block with SCK_HALF set to 2, so every clock level lasts two system cycles. This exposes off-by-one errors in the half-period counter and in the point where the rising edge samples input, which a divide-by-two build would hide. A behavioural flash model shifts its reply pattern on falling `sck` edges once the slots before the data phase have passed. This lets read results on one, two and four lanes be compared against the expected bytes, with the unreceived bytes zero.

// File: rtl/spi_mseq.sv
module spi_mseq #(
  parameter int SCK_HALF = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        cs_n,
  output logic        sck,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);

  localparam int HCW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [HCW-1:0] HC_LAST = HCW'(SCK_HALF - 1);

  typedef enum logic [2:0] {
    P_IDLE = 3'd0, P_CMD = 3'd1, P_ADDR = 3'd2, P_DMY = 3'd3, P_DATA = 3'd4
  } phase_t;

  phase_t      phase, np, from;
  logic [7:0]  r_cmd;
  logic [31:0] r_addr, r_wdata, r_rdata, sh, ld_sh, samp;
  logic [4:0]  r_dcnt;
  logic [17:0] r_cfg;
  logic        r_re, r_we, r_keep, done, ph;
  logic [5:0]  cnt, ld_cnt, lanes;
  logic [HCW-1:0] hc;
  logic [1:0]  ls_cur;

  function automatic logic [1:0] lsh(input logic [1:0] code);
    return (code == 2'd1) ? 2'd1 : (code == 2'd2) ? 2'd2 : 2'd0;
  endfunction

  wire busy    = (phase != P_IDLE);
  wire ctl_wr  = bus_wr && !busy && (bus_addr == 3'd0);
  wire st      = ctl_wr && bus_wdata[0];
  wire c_re    = ctl_wr ? bus_wdata[1] : r_re;
  wire c_we    = ctl_wr ? bus_wdata[2] : r_we;
  wire tick    = (hc == HC_LAST);
  wire [2:0] ab = 3'($countones(r_cfg[7:4]));
  wire [2:0] db = 3'($countones(r_cfg[11:8]));
  wire [5:0] nbits_a = {ab, 3'b000};
  wire [5:0] nbits_d = {db, 3'b000};
  wire [1:0] ls_c = lsh(r_cfg[13:12]);
  wire [1:0] ls_a = lsh(r_cfg[15:14]);
  wire [1:0] ls_d = lsh(r_cfg[17:16]);
  wire data_on = (r_cfg[11:8] != 4'd0) && (c_re || c_we);
  wire rd_data = (phase == P_DATA) && r_re;
  wire drive   = (phase == P_CMD) || (phase == P_ADDR) || ((phase == P_DATA) && !r_re);

  logic unused_bits;
  assign unused_bits = ^bus_wdata[31:18];

  always_comb begin
    from = st ? P_IDLE : phase;
    np = P_IDLE;
    if (data_on && from < P_DATA)   np = P_DATA;
    if (r_cfg[1] && from < P_DMY)   np = P_DMY;
    if (ab != 3'd0 && from < P_ADDR) np = P_ADDR;
    if (r_cfg[0] && from < P_CMD)   np = P_CMD;
  end

  always_comb begin
    ld_cnt = 6'd0;
    ld_sh  = 32'd0;
    case (np)
      P_CMD: begin
        ld_cnt = (6'd8 >> ls_c) - 6'd1;
        ld_sh  = {r_cmd, 24'd0};
      end
      P_ADDR: begin
        ld_cnt = (nbits_a >> ls_a) - 6'd1;
        ld_sh  = r_addr << (6'd32 - nbits_a);
      end
      P_DMY: ld_cnt = {1'b0, r_dcnt};
      P_DATA: begin
        ld_cnt = (nbits_d >> ls_d) - 6'd1;
        ld_sh  = c_re ? 32'd0 : r_wdata;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (phase)
      P_CMD:   ls_cur = ls_c;
      P_ADDR:  ls_cur = ls_a;
      P_DATA:  ls_cur = ls_d;
      default: ls_cur = 2'd0;
    endcase
  end

  assign lanes = 6'd1 << ls_cur;

  always_comb begin
    case (ls_cur)
      2'd2:    samp = {28'd0, io_in};
      2'd1:    samp = {30'd0, io_in[1:0]};
      default: samp = {31'd0, io_in[1]};
    endcase
  end

  assign io_oe  = !drive ? 4'h0 : (ls_cur == 2'd2) ? 4'hF : (ls_cur == 2'd1) ? 4'h3 : 4'h1;
  assign io_out = ((ls_cur == 2'd2) ? sh[31:28] :
                   (ls_cur == 2'd1) ? {2'b00, sh[31:30]} : {3'b000, sh[31]}) & io_oe;
  assign sck = ph;

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {28'd0, r_keep, r_we, r_re, 1'b0};
      3'd1:    bus_rdata = {24'd0, r_cmd};
      3'd2:    bus_rdata = r_addr;
      3'd3:    bus_rdata = {27'd0, r_dcnt};
      3'd4:    bus_rdata = {14'd0, r_cfg};
      3'd5:    bus_rdata = r_wdata;
      3'd6:    bus_rdata = r_rdata;
      default: bus_rdata = {30'd0, !cs_n, done};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE; r_cmd <= '0; r_addr <= '0; r_wdata <= '0; r_rdata <= '0;
      r_dcnt <= '0; r_cfg <= '0; r_re <= 1'b0; r_we <= 1'b0; r_keep <= 1'b0;
      done <= 1'b0; ph <= 1'b0; cs_n <= 1'b1; cnt <= '0; sh <= '0; hc <= '0;
    end else begin
      if (bus_wr && !busy) begin
        case (bus_addr)
          3'd0: {r_keep, r_we, r_re} <= bus_wdata[3:1];
          3'd1: r_cmd   <= bus_wdata[7:0];
          3'd2: r_addr  <= bus_wdata;
          3'd3: r_dcnt  <= bus_wdata[4:0];
          3'd4: r_cfg   <= bus_wdata[17:0];
          3'd5: r_wdata <= bus_wdata;
          default: ;
        endcase
      end
      if (st) begin
        phase <= np;
        hc    <= '0;
        ph    <= 1'b0;
        cnt   <= ld_cnt;
        sh    <= ld_sh;
        if (np == P_IDLE) begin
          done <= 1'b1;
          cs_n <= !bus_wdata[3];
        end else begin
          done <= 1'b0;
          cs_n <= 1'b0;
        end
      end else if (busy) begin
        hc <= tick ? '0 : hc + HCW'(1);
        if (tick && !ph) begin
          ph <= 1'b1;
          if (rd_data) sh <= (sh << lanes) | samp;
        end else if (tick && ph) begin
          ph <= 1'b0;
          if (cnt != 6'd0) begin
            cnt <= cnt - 6'd1;
            if (!rd_data) sh <= sh << lanes;
          end else begin
            if (rd_data) r_rdata <= sh << (6'd32 - nbits_d);
            phase <= np;
            cnt   <= ld_cnt;
            sh    <= ld_sh;
            if (np == P_IDLE) begin
              done <= 1'b1;
              cs_n <= !r_keep;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_mseq_chk.sv
module spi_mseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic       start_bit,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] io_oe,
  input logic       busy,
  input logic       done
);

  wire acc = bus_wr && (bus_addr == 3'd0) && start_bit && !busy;

  AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n); // R1

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck); // R1

  AST_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0) || (io_oe == 4'h1) || (io_oe == 4'h3) || (io_oe == 4'hF)); // R5

  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n); // R8

  AST_DONE_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !acc) |=> done); // R9

  AST_START_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (busy || done)); // R11

endmodule

bind spi_mseq spi_mseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .start_bit(bus_wdata[0]), .cs_n(cs_n), .sck(sck), .io_oe(io_oe),
  .busy(busy), .done(done)
);

// File: tb/sim_spi_mseq.sv
module sim_spi_mseq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic cs_n, sck;
  logic [3:0] io_out, io_oe, io_in;

  spi_mseq #(.SCK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cs_n(cs_n), .sck(sck),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errs = 0, checks = 0;
  bit run = 0, idle_cs = 1, finished = 0;
  logic [9:0] exp_q[$];
  logic [7:0]  t_cmd;
  logic [31:0] t_addr, t_wdata, t_pat;
  logic [4:0]  t_dcnt;
  logic [17:0] t_cfg;
  logic [31:0] slave_sh = '0;
  int sl_ls = 0, sl_pre = 0, fall_cnt = 0;
  bit sl_on = 0;

  always_comb begin
    case (sl_ls)
      2:       io_in = slave_sh[31:28];
      1:       io_in = {2'b00, slave_sh[31:30]};
      default: io_in = {2'b00, slave_sh[31], 1'b0};
    endcase
  end

  always @(negedge sck) if (sl_on) begin
    fall_cnt++;
    if (fall_cnt > sl_pre) slave_sh = slave_sh << (1 << sl_ls);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(negedge clk) if (run) begin
    logic [9:0] e, a;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : {idle_cs, 9'd0};
    a = {cs_n, sck, io_oe, io_out};
    chk(a === e, "R1 pin trace (cs,sck,oe,out)", 32'(a), 32'(e));
  end

  function automatic int ls_of(input logic [1:0] c);
    return (c == 2'd1) ? 1 : (c == 2'd2) ? 2 : 0;
  endfunction

  task automatic push_slot(input logic [3:0] m, input logic [3:0] o);
    repeat (HALF) exp_q.push_back({1'b0, 1'b0, m, o});
    repeat (HALF) exp_q.push_back({1'b0, 1'b1, m, o});
  endtask

  task automatic push_bits(input logic [31:0] v, input int nbits, input int ls, input bit drv);
    int L;
    logic [31:0] w;
    L = 1 << ls;
    w = v;
    for (int s = 0; s < nbits / L; s++) begin
      logic [3:0] m, o;
      m = 4'((1 << L) - 1);
      o = 4'(w[31:28] >> (4 - L));
      if (!drv) begin m = 4'h0; o = 4'h0; end
      push_slot(m, o);
      w = w << L;
    end
  endtask

  task automatic model_start(input bit keep, input bit re, input bit we);
    int ab, db, lc, la, ld, pre;
    ab = $countones(t_cfg[7:4]);
    db = $countones(t_cfg[11:8]);
    lc = ls_of(t_cfg[13:12]);
    la = ls_of(t_cfg[15:14]);
    ld = ls_of(t_cfg[17:16]);
    pre = 0;
    if (t_cfg[0]) begin push_bits({t_cmd, 24'd0}, 8, lc, 1); pre += 8 >> lc; end
    if (ab > 0) begin push_bits(t_addr << (32 - 8*ab), 8*ab, la, 1); pre += (8*ab) >> la; end
    if (t_cfg[1]) begin repeat (int'(t_dcnt) + 1) push_slot(4'h0, 4'h0); pre += int'(t_dcnt) + 1; end
    if (db > 0 && (re || we)) push_bits(re ? 32'd0 : t_wdata, 8*db, ld, !re);
    idle_cs = !keep;
    slave_sh = t_pat; sl_ls = ld; sl_pre = pre; fall_cnt = 0; sl_on = 1;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic setup(input logic [7:0] c, input logic [31:0] ad, input logic [4:0] dc,
                       input logic [17:0] cf, input logic [31:0] wd, input logic [31:0] pat);
    bus_write(3'd1, {24'd0, c});
    bus_write(3'd2, ad);
    bus_write(3'd3, {27'd0, dc});
    bus_write(3'd4, {14'd0, cf});
    bus_write(3'd5, wd);
    t_cmd = c; t_addr = ad; t_dcnt = dc; t_cfg = cf; t_wdata = wd; t_pat = pat;
  endtask

  task automatic start(input bit keep, input bit re, input bit we);
    bit acc;
    acc = (exp_q.size() == 0);
    bus_write(3'd0, {28'd0, keep, we, re, 1'b1});
    if (acc) model_start(keep, re, we);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0 && io_oe === 4'h0, "R12 reset pins",
        {29'd0, cs_n, sck, |io_oe}, 32'h4);
    rst_n = 1'b1;
    run = 1;
    for (int a = 0; a < 8; a++) begin
      bus_read(3'(a), r);
      chk(r === 32'd0, "R12 register reset value", r, 32'd0);
    end

    // R2: opcode only, single lane
    setup(8'hA5, 32'd0, 5'd0, 18'h00001, 32'd0, 32'd0);
    start(0, 0, 0);
    wait_idle();
    bus_read(3'd7, r);
    chk(r === 32'd1, "R9 status after opcode-only", r, 32'd1);

    // R3 R6: opcode + 3-byte address + 1-byte write, single lane
    setup(8'h02, 32'hFF123456, 5'd0, 18'h00871, 32'hC3112233, 32'd0);
    start(0, 0, 1);
    wait_idle();

    // R5 R7: quad opcode/address/data, 4 dummy slots, 4-byte read
    setup(8'hEB, 32'hDEADBEEF, 5'd3, 18'h2AF43, 32'd0, 32'h1234ABCD);
    start(0, 1, 0);
    wait_idle();
    bus_read(3'd6, r);
    chk(r === 32'h1234ABCD, "R7 quad read data", r, 32'h1234ABCD);

    // R5 R7: dual lanes, 2-byte read, 8 dummy slots
    setup(8'h3B, 32'h00ABCDEF, 5'd7, 18'h15C73, 32'd0, 32'h5AC39F00);
    start(0, 1, 0);
    wait_idle();
    bus_read(3'd6, r);
    chk(r === 32'h5AC30000, "R7 dual read two bytes", r, 32'h5AC30000);

    // R7: single-lane 1-byte read with read and write both set
    setup(8'h03, 32'd0, 5'd0, 18'h00801, 32'hFFFFFFFF, 32'hB7665544);
    start(0, 1, 1);
    wait_idle();
    bus_read(3'd6, r);
    chk(r === 32'hB7000000, "R7 single read one byte", r, 32'hB7000000);

    // R8: hold select then data-only continuation, quad write
    setup(8'h32, 32'h01020304, 5'd0, 18'h000F1, 32'd0, 32'd0);
    start(1, 0, 0);
    wait_idle();
    bus_read(3'd7, r);
    chk(r === 32'd3, "R8 frame held after first start", r, 32'd3);
    setup(8'h32, 32'h01020304, 5'd0, 18'h20F00, 32'h89ABCDEF, 32'd0);
    start(0, 0, 1);
    wait_idle();
    bus_read(3'd7, r);
    chk(r === 32'd1, "R8 frame released after continuation", r, 32'd1);

    // R5: lane code 3 acts as single lane
    setup(8'h81, 32'd0, 5'd0, 18'h03001, 32'd0, 32'd0);
    start(0, 0, 0);
    wait_idle();

    // R4: 32 dummy slots
    setup(8'h0B, 32'd0, 5'd31, 18'h00003, 32'd0, 32'd0);
    start(0, 0, 0);
    wait_idle();

    // R10: writes during a transaction are ignored
    setup(8'h11, 32'hCAFEF00D, 5'd0, 18'h000F1, 32'd0, 32'd0);
    start(0, 0, 0);
    bus_read(3'd7, r);
    chk(r === 32'd2, "R9 status while running", r, 32'd2);
    bus_write(3'd1, 32'h77);
    start(0, 0, 0);
    bus_write(3'd4, 32'h0);
    wait_idle();
    bus_read(3'd1, r);
    chk(r === 32'h11, "R10 opcode unchanged by busy write", r, 32'h11);
    bus_read(3'd4, r);
    chk(r === 32'h000F1, "R10 setup unchanged by busy write", r, 32'h000F1);

    // R11: nothing enabled finishes at once
    bus_write(3'd0, 32'h0);
    setup(8'h00, 32'd0, 5'd0, 18'h00000, 32'd0, 32'd0);
    start(0, 0, 0);
    bus_read(3'd7, r);
    chk(r === 32'd1, "R11 immediate finish", r, 32'd1);

    // R7: data mask set but neither direction bit: data skipped
    setup(8'h66, 32'd0, 5'd0, 18'h00F01, 32'hFFFFFFFF, 32'd0);
    start(0, 0, 0);
    bus_read(3'd7, r);
    chk(r === 32'd2, "R9 done cleared on accepted start", r, 32'd2);
    wait_idle();

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule